// File: doc/BRIEF.md
# Registered Integer Execute-Stage ALU

This block is the arithmetic and logic stage of a small integer datapath. Each cycle it takes two n-bit operands and a 3-bit operation code. It computes one of eight functions: add, subtract, AND, OR, NOR, signed set-on-less-than, and logical shifts in either direction. It produces an n-bit result and four status flags: zero, carry, overflow and sign.

The result and the flags sit in a single register stage that loads on the rising clock edge, so the block can serve as the execute stage of a pipeline. An enable input decides whether that register loads. While enable is low, the outputs keep the last values they captured. A synchronous, active-high reset clears the register.

Top module: `exec_alu`

## Requirements
- R1: Operation code 3'b000 adds. The result is (A+B) mod 2^n. Carry is the carry-out of bit n-1. Overflow is 1 when A and B have the same sign bit and the result's sign bit differs from it.
- R2: Operation code 3'b001 subtracts, computed as A + ~B + 1. The result is (A-B) mod 2^n. Carry is the adder carry-out, so it is 1 exactly when A >= B as unsigned values. Overflow is 1 when A and B differ in sign and the result's sign differs from A's sign.
- R3: Operation codes 3'b010, 3'b011 and 3'b101 give bitwise A AND B, A OR B and NOT(A OR B). Carry and overflow are 0 for all three.
- R4: Operation code 3'b100 gives 1 when A < B as two's-complement signed values, and 0 otherwise. The result is zero-extended to n bits. Carry and overflow are 0.
- R5: Operation code 3'b110 shifts A left by the value of the low log2(n) bits of B and fills with zeros. The upper bits of B have no effect. Carry and overflow are 0.
- R6: Operation code 3'b111 shifts A right logically by the value of the low log2(n) bits of B and fills with zeros. Carry and overflow are 0.
- R7: After any captured operation, the zero flag is 1 exactly when all n result bits are 0. The sign flag equals result bit n-1.
- R8: While enable is low, the result and all four flags keep their values, whatever the operands and operation code do.
- R9: The outputs change only at a rising clock edge. Inputs presented with enable high appear at the outputs just after the next rising edge, and not before it.
- R10: A rising edge with reset high sets the result and all four flags to 0, whatever the enable input is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Lets the output register load this cycle |
| op_code | input | 3 | Operation select |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B; its low log2(WIDTH) bits give the shift amount |
| res | output | WIDTH | Registered result |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered signed-overflow flag |
| flag_n | output | 1 | Registered sign flag |

## Verification
The bench builds the block with WIDTH set to 8. That makes the shift amount 3 bits wide, so every shift distance from 0 to 7 comes up often. Random operands also land regularly on the signed and unsigned wrap points, such as 8'h7F+1, 8'hFF+1 and 8'h80-1. Directed vectors pin down the carry and overflow corners, equal and opposite-sign comparisons, and upper bits of B that a shift must ignore. They also cover the enable-low hold, the one-edge latency and a reset that arrives while enable is high.

// File: rtl/exec_alu_pkg.sv
package exec_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_SLT = 3'b100,
    OP_NOR = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic c;
    logic v;
    logic n;
  } alu_flags_t;

  function automatic logic op_is_arith(alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

endpackage

// File: rtl/exec_alu_addsub.sv
module exec_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf,
  output logic             lt
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // In subtract mode B is inverted and the +1 enters as the carry-in.
  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
  assign sum   = full[MSB:0];
  assign cout  = full[WIDTH];
  // Overflow: the adder's two inputs agree in sign but the sum does not.
  assign ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
  // Signed less-than: the sign of the difference, corrected by overflow.
  assign lt    = sum[MSB] ^ ovf;

endmodule

// File: rtl/exec_alu_bitwise.sv
module exec_alu_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] nor_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
    assign nor_o[i] = ~(a[i] | b[i]);
  end

endmodule

// File: rtl/exec_alu_shifter.sv
module exec_alu_shifter #(
  parameter int WIDTH    = 32,
  parameter int SHW      = 5,
  parameter bit DIR_LEFT = 1'b1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SHW-1:0]   amt,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [0:SHW];

  assign stg[0] = din;

  // Stage i shifts by 2**i when bit i of the amount is set; vacated bits take 0.
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    logic [WIDTH-1:0] moved;
    if (DIR_LEFT) begin : g_left
      assign moved = stg[i] << STEP;
    end else begin : g_right
      assign moved = stg[i] >> STEP;
    end
    assign stg[i+1] = amt[i] ? moved : stg[i];
  end

  assign dout = stg[SHW];

endmodule

// File: rtl/exec_alu.sv
module exec_alu
  import exec_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       op_code,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v,
  output logic             flag_n
);
  localparam int MSB = WIDTH - 1;
  localparam int SHW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  alu_op_e op;
  assign op = alu_op_e'(op_code);

  // Shared adder: ADD, SUB and SLT all go through it.
  logic [WIDTH-1:0] as_sum;
  logic             as_cout, as_ovf, as_lt;

  exec_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a    (opa),
    .b    (opb),
    .sub  (op != OP_ADD),
    .sum  (as_sum),
    .cout (as_cout),
    .ovf  (as_ovf),
    .lt   (as_lt)
  );

  logic [WIDTH-1:0] bw_and, bw_or, bw_nor;

  exec_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a     (opa),
    .b     (opb),
    .and_o (bw_and),
    .or_o  (bw_or),
    .nor_o (bw_nor)
  );

  logic [SHW-1:0]   sh_amt;
  logic [WIDTH-1:0] sh_left, sh_right;

  assign sh_amt = opb[SHW-1:0];

  exec_alu_shifter #(.WIDTH(WIDTH), .SHW(SHW), .DIR_LEFT(1'b1)) u_shl (
    .din  (opa),
    .amt  (sh_amt),
    .dout (sh_left)
  );

  exec_alu_shifter #(.WIDTH(WIDTH), .SHW(SHW), .DIR_LEFT(1'b0)) u_shr (
    .din  (opa),
    .amt  (sh_amt),
    .dout (sh_right)
  );

  logic [WIDTH-1:0] nxt_res;
  alu_flags_t       nxt_flg;

  always_comb begin
    unique case (op)
      OP_ADD,
      OP_SUB:  nxt_res = as_sum;
      OP_AND:  nxt_res = bw_and;
      OP_OR:   nxt_res = bw_or;
      OP_NOR:  nxt_res = bw_nor;
      OP_SLT:  nxt_res = {{(WIDTH-1){1'b0}}, as_lt};
      OP_SHL:  nxt_res = sh_left;
      default: nxt_res = sh_right;
    endcase
  end

  always_comb begin
    nxt_flg.z = (nxt_res == '0);
    nxt_flg.n = nxt_res[MSB];
    nxt_flg.c = op_is_arith(op) ? as_cout : 1'b0;
    nxt_flg.v = op_is_arith(op) ? as_ovf  : 1'b0;
  end

  logic [WIDTH-1:0] res_q;
  alu_flags_t       flg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (en) begin
      res_q <= nxt_res;
      flg_q <= nxt_flg;
    end
  end

  assign res    = res_q;
  assign flag_z = flg_q.z;
  assign flag_c = flg_q.c;
  assign flag_v = flg_q.v;
  assign flag_n = flg_q.n;

  // R10: reset clears everything on the following cycle.
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (res == '0) && !flag_z && !flag_c && !flag_v && !flag_n);

  // R8: an idle cycle leaves the outputs untouched.
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(res) && $stable(flag_z) && $stable(flag_c) &&
            $stable(flag_v) && $stable(flag_n));

  // R1: the captured sum matches the operands of the previous cycle.
  a_r1_add_sum: assert property (@(posedge clk) disable iff (rst)
    (en && op_code == 3'b000) |=> res == ($past(opa) + $past(opb)));

  // R4: set-on-less-than gives 0 or 1, with no carry or overflow.
  a_r4_slt_shape: assert property (@(posedge clk) disable iff (rst)
    (en && op_code == 3'b100) |=> (res[MSB:1] == '0) && !flag_c && !flag_v);

  // R3: logic and shift operations never raise carry or overflow.
  a_r3_no_carry_logic: assert property (@(posedge clk) disable iff (rst)
    (en && (op_code[2] || op_code[1])) |=> !flag_c && !flag_v);

  // R7: zero and sign flags agree with the captured result.
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    en |=> flag_z == (res == '0));

  a_r7_sign_flag: assert property (@(posedge clk) disable iff (rst)
    en |=> flag_n == res[MSB]);

endmodule

// File: tb/sim_exec_alu.sv
module sim_exec_alu;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         en;
  logic [2:0]   op_code;
  logic [W-1:0] opa, opb;
  logic [W-1:0] res;
  logic         flag_z, flag_c, flag_v, flag_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  exec_alu #(.WIDTH(W)) u0 (
    .clk (clk), .rst (rst), .en (en), .op_code (op_code),
    .opa (opa), .opb (opb), .res (res),
    .flag_z (flag_z), .flag_c (flag_c), .flag_v (flag_v), .flag_n (flag_n)
  );

  // Reference: returns {result, c, v}.
  function automatic logic [W+1:0] ref_rcv(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0]   wide;
    logic [W-1:0] r;
    logic         c, v;
    c = 1'b0; v = 1'b0; r = '0;
    case (op)
      3'b000: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[W-1:0]; c = wide[W];
        v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'b001: begin
        r = a - b; c = (a >= b);
        v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      3'b010: r = a & b;
      3'b011: r = a | b;
      3'b101: r = ~(a | b);
      3'b100: r = ($signed(a) < $signed(b)) ? 8'd1 : 8'd0;
      3'b110: r = a << b[2:0];
      default: r = a >> b[2:0];
    endcase
    return {r, c, v};
  endfunction

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b100: return "R4";
      3'b110: return "R5";
      3'b111: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, check at the next falling edge.
  task automatic run_op(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b);
    logic [W+1:0] e;
    @(negedge clk);
    en = 1'b1; op_code = op; opa = a; opb = b;
    @(negedge clk);
    e = ref_rcv(op, a, b);
    check(op_tag(op), {22'd0, res, flag_c, flag_v}, {22'd0, e});
    check("R7", {30'd0, flag_z, flag_n}, {30'd0, (e[W+1:2] == '0), e[W+1]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h00C0FFEE);
    rst = 1'b1; en = 1'b1; op_code = 3'b000; opa = 8'hFF; opb = 8'hFF;
    repeat (3) @(negedge clk);
    // R10: reset state with enable high.
    check("R10", {23'd0, res, flag_z, flag_c, flag_v, flag_n}, 32'd0);
    rst = 1'b0; en = 1'b0;

    // Directed corners.
    run_op(3'b000, 8'h7F, 8'h01);   // R1 signed overflow
    run_op(3'b000, 8'hFF, 8'h01);   // R1 carry, zero result
    run_op(3'b000, 8'h80, 8'h80);   // R1 carry + overflow
    run_op(3'b001, 8'h80, 8'h01);   // R2 overflow
    run_op(3'b001, 8'h00, 8'h00);   // R2 carry set, zero
    run_op(3'b001, 8'h01, 8'h02);   // R2 borrow
    run_op(3'b100, 8'h80, 8'h7F);   // R4 negative < positive
    run_op(3'b100, 8'h7F, 8'h80);   // R4
    run_op(3'b100, 8'h33, 8'h33);   // R4 equal
    run_op(3'b101, 8'h00, 8'h00);   // R3 NOR all ones
    run_op(3'b110, 8'h81, 8'h09);   // R5 upper B bits ignored
    run_op(3'b110, 8'hFF, 8'h07);   // R5
    run_op(3'b111, 8'h80, 8'hF8);   // R6 shift by 0
    run_op(3'b111, 8'h80, 8'h07);   // R6

    // R9: latency of one rising edge.
    run_op(3'b000, 8'h01, 8'h02);
    @(negedge clk);
    en = 1'b1; op_code = 3'b000; opa = 8'h05; opb = 8'h05;
    #1;
    check("R9", {24'd0, res}, 32'd3);
    @(posedge clk);
    #1;
    check("R9", {24'd0, res}, 32'd10);

    // R8: enable low holds outputs.
    @(negedge clk);
    en = 1'b0; op_code = 3'b001; opa = 8'h00; opb = 8'h11;
    repeat (3) @(negedge clk);
    check("R8", {23'd0, res, flag_z, flag_c, flag_v, flag_n}, {23'd0, 8'd10, 4'b0000});

    // Random mix.
    for (int i = 0; i < 3000; i++) begin
      logic [2:0]   rop;
      logic [W-1:0] ra, rb;
      rop = 3'($urandom);
      ra  = 8'($urandom);
      rb  = 8'($urandom);
      if (i % 16 == 0) ra = 8'h80;
      if (i % 16 == 1) rb = 8'h7F;
      run_op(rop, ra, rb);
    end

    // R10: reset mid-run dominates enable.
    @(negedge clk);
    rst = 1'b1; en = 1'b1; op_code = 3'b000; opa = 8'h12; opb = 8'h34;
    @(negedge clk);
    check("R10", {23'd0, res, flag_z, flag_c, flag_v, flag_n}, 32'd0);
    rst = 1'b0; en = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule